// File: doc/BRIEF.md
# Iterative Fixed-Point Square Root Unit

This block computes the square root of an unsigned fixed-point operand. It uses the restoring digit-by-digit binary method. A single subtract-and-compare datapath settles one bit of the root on every clock cycle. The operand is held in a shift register and is consumed two bits at a time, starting from its most significant pair. Each cycle the next pair is appended to a running remainder. The current root, extended by binary 01, is then trial-subtracted from that remainder. If the difference is not negative, it becomes the new remainder and a 1 is shifted into the root. If it is negative, the remainder keeps its value and a 0 is shifted in.

The operand is treated as an integer of `DATA_W` bits with `FRAC_W` zero bits appended below it. The unit therefore runs `DATA_W/2 + FRAC_W/2` iterations. Once the operand bits are used up, the later iterations shift in zero pairs. The root carries `FRAC_W/2` fractional bits. More fractional precision costs cycles and a wider root register, but no extra arithmetic.

A caller pulses `start` with the operand on `din` while the unit is idle. The caller then waits for the one-cycle `done` pulse and reads `root`, which holds its value until the next accepted start.

Top module: `fxp_sqrt_iter`

## Requirements
- R1: After an accepted start with operand X, the `root` value shown while `done` is high equals floor(sqrt(X * 2^FRAC_W)). This includes X = 0 and X = 2^DATA_W - 1.
- R2: `done` rises exactly ITERS = DATA_W/2 + FRAC_W/2 clock cycles after the edge that accepts `start`, and only at the end of a run.
- R3: `busy` is high from the cycle after an accepted start up to and including the last iteration cycle. It is low at all other times and never high together with `done`.
- R4: `done` is high for exactly one cycle per computation.
- R5: A `start` pulse while `busy` is high is ignored: the running computation's result and its `done` timing are unchanged.
- R6: While the unit is idle and no start is accepted, `root` keeps its value, including in the cycles after `done` falls.
- R7: After reset, `busy` and `done` are low and `root` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation; taken only while idle |
| din | input | DATA_W | Unsigned operand, sampled on the accepting edge |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when the root is final |
| root | output | DATA_W/2+FRAC_W/2 | Square root with FRAC_W/2 fractional bits |

## Verification
The assertions assume that `start` is a clean synchronous level: it is never unknown once reset is released, and it changes only away from the rising edge. The latency and stability properties rely on that. The stimulus drives `start` and `din` only on falling edges and releases `start` one cycle after acceptance, except in runs that deliberately hold or re-pulse it during `busy` to probe the ignore rule. A narrow configuration is swept over every operand. The wide default configuration gets boundary operands and a pseudo-random series, so every input the checker sees obeys the same handshake discipline.

// File: rtl/fxp_sqrt_pkg.sv
package fxp_sqrt_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } sqrtCtrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sqrtState_t;
endpackage

// File: rtl/fxp_sqrt_ctrl.sv
module fxp_sqrt_ctrl
  import fxp_sqrt_pkg::*;
#(
  parameter int ITERS = 24
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  output sqrtCtrl_t strb,
  output logic      busy,
  output logic      done
);
  localparam int CNT_W = $clog2(ITERS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

  sqrtState_t state;
  logic [CNT_W-1:0] iterCnt;
  logic doneReg;

  always_comb begin
    strb.load = (state == ST_IDLE) && start;
    strb.step = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);
  assign done = doneReg;
endmodule

// File: rtl/fxp_sqrt_datapath.sv
module fxp_sqrt_datapath
  import fxp_sqrt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  sqrtCtrl_t                          strb,
  input  logic [DATA_W-1:0]                  din,
  output logic [DATA_W/2+FRAC_W/2-1:0]       root
);
  localparam int ROOT_W = DATA_W/2 + FRAC_W/2;
  localparam int EXT_W  = 2 * ROOT_W;
  localparam int REM_W  = ROOT_W + 2;

  logic [EXT_W-1:0]  opShift;
  logic [REM_W-1:0]  remReg;
  logic [ROOT_W-1:0] rootReg;

  logic [REM_W-1:0] remNext;
  logic [REM_W-1:0] subtrahend;
  logic [REM_W:0]   trialDiff;
  logic             trialNeg;

  always_comb begin
    remNext    = {remReg[REM_W-3:0], opShift[EXT_W-1 -: 2]};
    subtrahend = {rootReg, 2'b01};
    trialDiff  = {1'b0, remNext} - {1'b0, subtrahend};
    trialNeg   = trialDiff[REM_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opShift <= '0;
      remReg  <= '0;
      rootReg <= '0;
    end else if (strb.load) begin
      opShift <= EXT_W'(din) << FRAC_W;
      remReg  <= '0;
      rootReg <= '0;
    end else if (strb.step) begin
      opShift <= opShift << 2;
      remReg  <= trialNeg ? remNext : trialDiff[REM_W-1:0];
      rootReg <= {rootReg[ROOT_W-2:0], ~trialNeg};
    end
  end

  assign root = rootReg;
endmodule

// File: rtl/fxp_sqrt_iter.sv
module fxp_sqrt_iter
  import fxp_sqrt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [DATA_W-1:0]            din,
  output logic                         busy,
  output logic                         done,
  output logic [DATA_W/2+FRAC_W/2-1:0] root
);
  localparam int ITERS = DATA_W/2 + FRAC_W/2;

  sqrtCtrl_t strb;

  fxp_sqrt_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  fxp_sqrt_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strb  (strb),
    .din   (din),
    .root  (root)
  );
endmodule

// File: rtl/fxp_sqrt_iter_chk.sv
module fxp_sqrt_iter_chk #(
  parameter int ITERS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [ITERS-1:0] root
);
  localparam int RC_W = $clog2(ITERS + 1) + 1;
  logic [RC_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runCnt <= '0;
    else if (start && !busy) runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R3
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (runCnt == RC_W'(ITERS))); // R2
  AST_ROOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(root)); // R6
endmodule

bind fxp_sqrt_iter fxp_sqrt_iter_chk #(.ITERS(DATA_W/2 + FRAC_W/2)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .root  (root)
);

// File: tb/fxp_sqrt_iter_bench.sv
module fxp_sqrt_iter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int S_DW = 8;
  localparam int S_FW = 4;
  localparam int S_IT = S_DW/2 + S_FW/2;
  localparam int B_DW = 32;
  localparam int B_FW = 16;
  localparam int B_IT = B_DW/2 + B_FW/2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startS = 1'b0, startB = 1'b0;
  logic [S_DW-1:0] dinS = '0;
  logic [B_DW-1:0] dinB = '0;
  logic busyS, doneS, busyB, doneB;
  logic [S_IT-1:0] rootS;
  logic [B_IT-1:0] rootB;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxp_sqrt_iter #(.DATA_W(S_DW), .FRAC_W(S_FW)) u_fxp_sqrt_iter_s (
    .clk(clk), .rst_n(rst_n), .start(startS), .din(dinS),
    .busy(busyS), .done(doneS), .root(rootS));

  fxp_sqrt_iter u_fxp_sqrt_iter (
    .clk(clk), .rst_n(rst_n), .start(startB), .din(dinB),
    .busy(busyB), .done(doneB), .root(rootB));

  function automatic longint unsigned isqrt(longint unsigned v);
    longint unsigned r = 0;
    for (int b = 31; b >= 0; b--) begin
      longint unsigned t = r | (64'd1 << b);
      if (t <= v / t) r = t;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One computation on the selected instance; poke re-pulses start mid-run (R5)
  task automatic runOne(bit big, longint unsigned x, bit poke, bit full);
    longint unsigned exp;
    longint unsigned held;
    int n = 0;
    int iters = big ? B_IT : S_IT;
    exp = isqrt(x << (big ? B_FW : S_FW));
    @(negedge clk);
    if (big) begin startB = 1; dinB = B_DW'(x); end
    else begin startS = 1; dinS = S_DW'(x); end
    @(negedge clk);
    if (big) startB = 0; else startS = 0;
    if (full) check((big ? busyB : busyS) == 1'b1, "R3 busy after start", 0, 1);
    while (!(big ? doneB : doneS) && n < 100) begin
      if (poke && n == 2) begin
        if (big) begin startB = 1; dinB = ~dinB; end
        else begin startS = 1; dinS = ~dinS; end
      end
      if (poke && n == 3) begin
        if (big) startB = 0; else startS = 0;
      end
      if (full && n > 0) check((big ? busyB : busyS) == 1'b1, "R3 busy in run", 0, 1);
      @(negedge clk);
      n++;
    end
    held = big ? rootB : rootS;
    check(held == exp, poke ? "R5 result with start while busy" : "R1 root value", held, exp);
    if (full || poke)
      check(n == iters, poke ? "R5 latency with start while busy" : "R2 latency", n, iters);
    if (full) begin
      check((big ? busyB : busyS) == 1'b0, "R3 busy low at done", 1, 0);
      @(negedge clk);
      check((big ? doneB : doneS) == 1'b0, "R4 done single cycle", 1, 0);
      @(negedge clk);
      held = big ? rootB : rootS;
      check(held == exp, "R6 root held while idle", held, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busyB == 0 && doneB == 0 && rootB == 0, "R7 reset state wide", rootB, 0);
    check(busyS == 0 && doneS == 0 && rootS == 0, "R7 reset state narrow", rootS, 0);
    rst_n = 1;
    // narrow configuration: every operand
    for (int v = 0; v < 256; v++) runOne(1'b0, longint'(v), 1'b0, v < 4 || v == 255);
    runOne(1'b0, 8'd200, 1'b1, 1'b0);
    // wide configuration: boundaries (R1) and protocol corners
    runOne(1'b1, 0, 1'b0, 1'b1);
    runOne(1'b1, 1, 1'b0, 1'b1);
    runOne(1'b1, 2, 1'b0, 1'b1);
    runOne(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1);
    runOne(1'b1, 32'h8000_0000, 1'b0, 1'b1);
    runOne(1'b1, 32'h0001_0000, 1'b1, 1'b0);
    begin
      longint unsigned seed = 64'h1234_5678;
      for (int k = 0; k < 300; k++) begin
        seed = (seed * 64'd6364136223846793005 + 64'd1442695040888963407);
        runOne(1'b1, (seed >> 32) & 64'hFFFF_FFFF, 1'b0, 1'b0);
      end
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule